// File: doc/BRIEF.md
# Tag Free-List Allocator

This block owns a fixed pool of command tags and makes sure every command in flight carries a tag no other in-flight command holds. A requester asks for a tag and is told in the same cycle whether one was granted and which one. A completion path hands tags back. Free tags form a singly linked stack held in a next-pointer memory, so the tag released most recently is the next one granted.

Besides the links, each tag has an occupancy bit. A separate strobe sets this bit once the requester has actually placed a command under the tag. A bulk-cancel walk steps through every tag in ascending order, one tag per cycle. For each occupied tag it reports a cancellation and returns that tag to the free stack. While the walk runs, the block grants nothing and ignores returns and marks. A free-count output always tells how many tags can be granted.

Top module: `tagpool_lifo`

## Requirements
- R1: After reset, `free_count` equals the pool size (256), `cancel_busy` is 0, and successive grants return tags 0, 1, 2 and so on in ascending order.
- R2: A grant (`alloc_req` with `alloc_ok` = 1) returns the top of the free stack in the same cycle. Tags handed back are granted again in last-in, first-out order.
- R3: When no tag is free and no tag is handed back in the same cycle, `alloc_ok` is 0 and `alloc_tag` is 0. A request in that state changes no state.
- R4: When a tag is handed back and a grant is requested in the same cycle, the handed-back tag is granted in that cycle and `free_count` does not change.
- R5: `free_count` rises by one for each accepted return, falls by one for each grant, and equals the number of tags in the free stack.
- R6: `mark_req` sets the occupancy bit of `mark_tag`. The cancel walk later reports occupied tags through its outputs.
- R7: Handing a tag back clears its occupancy bit, so a bulk-cancel walk that follows does not report that tag.
- R8: `cancel_start`, when idle, starts a walk on the next cycle that lasts exactly 256 cycles with `cancel_busy` = 1. In walk cycle k, `cancel_valid` is 1 exactly when tag k is occupied, and `cancel_tag` is k. Each reported tag is returned to the free stack.
- R9: While `cancel_busy` is 1, `alloc_ok` is 0, and `alloc_req`, `free_req`, `mark_req` and `cancel_start` have no effect.
- R10: After a walk, the cancelled tags sit on the free stack in ascending push order, so the highest cancelled tag is granted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request one tag this cycle |
| alloc_ok | output | 1 | A tag is available for this cycle's request |
| alloc_tag | output | 8 | Tag granted (0 when `alloc_ok` is 0) |
| free_req | input | 1 | Hand a tag back |
| free_tag | input | 8 | Tag handed back |
| mark_req | input | 1 | Mark a held tag as carrying a command |
| mark_tag | input | 8 | Tag to mark |
| cancel_start | input | 1 | Begin a bulk-cancel walk |
| cancel_busy | output | 1 | Walk in progress |
| cancel_valid | output | 1 | Tag at the walk position is occupied and is being cancelled |
| cancel_tag | output | 8 | Tag being cancelled (0 when `cancel_valid` is 0) |
| free_count | output | 9 | Number of free tags |

## Verification
The properties assume that the requester hands back only tags it currently holds, and never the same tag twice. They also assume that marks apply only to held tags and never to the tag being handed back in the same cycle. The bench meets these assumptions by keeping its own list of held tags. It draws every return and every mark from that list, and it skips a mark whose tag matches the return in the same cycle. Random returns, grants and marks made during a walk still come from the held list, so the bench also checks that such inputs are ignored.

// File: rtl/tagpool_pkg.sv
package tagpool_pkg;
    // Pool configuration and derived widths
    localparam int unsigned POOL_TAGS = 256;
    localparam int unsigned TAG_W     = $clog2(POOL_TAGS);
    localparam int unsigned CNT_W     = $clog2(POOL_TAGS + 1);

    // One link of the free stack: vld = 0 stands for "no next tag"
    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } link_t;

    localparam link_t LINK_NONE = '{vld: 1'b0, tag: '0};

    typedef struct packed {
        link_t            head;
        logic [CNT_W-1:0] count;
        logic             busy;
        logic [TAG_W-1:0] idx;
    } pool_state_t;
endpackage

// File: rtl/tagpool_link_ram.sv
module tagpool_link_ram
    import tagpool_pkg::*;
#(
    parameter int unsigned DEPTH = POOL_TAGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  link_t            wr_link,
    input  logic [TAG_W-1:0] rd_tag,
    output link_t            rd_link
);
    link_t mem_q [DEPTH];

    // Each entry resets to point at its successor; the last one points nowhere
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam link_t RST_LINK = (g == DEPTH - 1) ? LINK_NONE
                                   : '{vld: 1'b1, tag: TAG_W'(g + 1)};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= RST_LINK;
            end else if (wr_en && (wr_tag == TAG_W'(g))) begin
                mem_q[g] <= wr_link;
            end
        end
    end

    assign rd_link = mem_q[rd_tag];
endmodule

// File: rtl/tagpool_occ.sv
module tagpool_occ
    import tagpool_pkg::*;
#(
    parameter int unsigned DEPTH = POOL_TAGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_tag,
    output logic [DEPTH-1:0] occ
);
    logic [DEPTH-1:0] occ_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                occ_q[g] <= 1'b0;
            end else if (clr_en && (clr_tag == TAG_W'(g))) begin
                occ_q[g] <= 1'b0;
            end else if (set_en && (set_tag == TAG_W'(g))) begin
                occ_q[g] <= 1'b1;
            end
        end
    end

    assign occ = occ_q;
endmodule

// File: rtl/tagpool_lifo.sv
module tagpool_lifo
    import tagpool_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    output logic             alloc_ok,
    output logic [TAG_W-1:0] alloc_tag,
    input  logic             free_req,
    input  logic [TAG_W-1:0] free_tag,
    input  logic             mark_req,
    input  logic [TAG_W-1:0] mark_tag,
    input  logic             cancel_start,
    output logic             cancel_busy,
    output logic             cancel_valid,
    output logic [TAG_W-1:0] cancel_tag,
    output logic [CNT_W-1:0] free_count
);
    localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(POOL_TAGS - 1);

    pool_state_t st_d, st_q;

    logic             ext_ok;
    logic             scan_hit;
    logic             push_en;
    logic [TAG_W-1:0] push_tag;
    logic             pop_en;
    logic             wr_en;
    logic [TAG_W-1:0] wr_tag;
    link_t            wr_link;
    link_t            nxt_link;
    logic [POOL_TAGS-1:0] occ_vec;

    tagpool_link_ram #(.DEPTH(POOL_TAGS)) u_links (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_tag  (wr_tag),
        .wr_link (wr_link),
        .rd_tag  (st_q.head.tag),
        .rd_link (nxt_link)
    );

    tagpool_occ #(.DEPTH(POOL_TAGS)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ext_ok && mark_req),
        .set_tag (mark_tag),
        .clr_en  (push_en),
        .clr_tag (push_tag),
        .occ     (occ_vec)
    );

    always_comb begin
        st_d     = st_q;
        ext_ok   = !st_q.busy;
        scan_hit = st_q.busy && occ_vec[st_q.idx];

        // A walk takes over the return path; outside a walk the port owns it
        push_en  = ext_ok ? free_req : scan_hit;
        push_tag = ext_ok ? free_tag : st_q.idx;

        // Grant view: a same-cycle return is granted ahead of the stack top
        alloc_ok  = ext_ok && (free_req || st_q.head.vld);
        alloc_tag = '0;
        if (ext_ok && free_req) begin
            alloc_tag = free_tag;
        end else if (ext_ok && st_q.head.vld) begin
            alloc_tag = st_q.head.tag;
        end
        pop_en = alloc_req && alloc_ok;

        wr_en   = 1'b0;
        wr_tag  = '0;
        wr_link = LINK_NONE;
        if (push_en && pop_en) begin
            // returned tag leaves at once; head and count unchanged
            wr_en  = 1'b1;
            wr_tag = push_tag;
        end else if (push_en) begin
            wr_en      = 1'b1;
            wr_tag     = push_tag;
            wr_link    = st_q.head;
            st_d.head  = '{vld: 1'b1, tag: push_tag};
            st_d.count = st_q.count + 1'b1;
        end else if (pop_en) begin
            wr_en      = 1'b1;
            wr_tag     = st_q.head.tag;
            st_d.head  = nxt_link;
            st_d.count = st_q.count - 1'b1;
        end

        // Bulk-cancel walk position
        if (st_q.busy) begin
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == LAST_TAG) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end
        end else if (cancel_start) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.head  <= '{vld: 1'b1, tag: '0};
            st_q.count <= CNT_W'(POOL_TAGS);
            st_q.busy  <= 1'b0;
            st_q.idx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cancel_busy  = st_q.busy;
    assign cancel_valid = scan_hit;
    assign cancel_tag   = scan_hit ? st_q.idx : '0;
    assign free_count   = st_q.count;
endmodule

// File: rtl/tagpool_lifo_chk.sv
module tagpool_lifo_chk
    import tagpool_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_req,
    input logic             alloc_ok,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             free_req,
    input logic [TAG_W-1:0] free_tag,
    input logic             cancel_busy,
    input logic             cancel_valid,
    input logic [TAG_W-1:0] cancel_tag,
    input logic [CNT_W-1:0] free_count
);
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        free_count <= CNT_W'(POOL_TAGS));

    p_grant_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cancel_busy && alloc_req && alloc_ok && !free_req)
        |=> free_count == $past(free_count) - 1'b1);

    p_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cancel_busy && !free_req) |-> (alloc_ok == (free_count != '0)));

    p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cancel_busy && alloc_req && free_req)
        |=> free_count == $past(free_count));

    p_walk_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_busy |-> !alloc_ok);

    p_walk_ascend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_valid && $past(cancel_valid) && $past(cancel_busy))
        |-> cancel_tag > $past(cancel_tag));

    p_cancel_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_valid |=> free_count == $past(free_count) + 1'b1);

    p_valid_in_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_valid |-> cancel_busy);
endmodule

bind tagpool_lifo tagpool_lifo_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_req    (alloc_req),
    .alloc_ok     (alloc_ok),
    .alloc_tag    (alloc_tag),
    .free_req     (free_req),
    .free_tag     (free_tag),
    .cancel_busy  (cancel_busy),
    .cancel_valid (cancel_valid),
    .cancel_tag   (cancel_tag),
    .free_count   (free_count)
);

// File: tb/sim_tagpool_lifo.sv
`timescale 1ns/1ps
module sim_tagpool_lifo;
    import tagpool_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_req = 1'b0;
    logic             alloc_ok;
    logic [TAG_W-1:0] alloc_tag;
    logic             free_req = 1'b0;
    logic [TAG_W-1:0] free_tag = '0;
    logic             mark_req = 1'b0;
    logic [TAG_W-1:0] mark_tag = '0;
    logic             cancel_start = 1'b0;
    logic             cancel_busy;
    logic             cancel_valid;
    logic [TAG_W-1:0] cancel_tag;
    logic [CNT_W-1:0] free_count;

    always #2.5 clk = ~clk;

    tagpool_lifo u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
        .free_req(free_req), .free_tag(free_tag),
        .mark_req(mark_req), .mark_tag(mark_tag),
        .cancel_start(cancel_start), .cancel_busy(cancel_busy),
        .cancel_valid(cancel_valid), .cancel_tag(cancel_tag),
        .free_count(free_count)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model: free stack, occupancy, held tags, walk state
    int stk [POOL_TAGS];
    int sp;
    bit occ [POOL_TAGS];
    int held [POOL_TAGS];
    int nheld;
    bit mbusy;
    int midx;

    function automatic int top_tag();
        return (sp > 0) ? stk[sp-1] : 0;
    endfunction

    function automatic int held_pos(int t);
        for (int i = 0; i < nheld; i++) if (held[i] == t) return i;
        return -1;
    endfunction

    task automatic check(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic drop_held(int t);
        int p;
        p = held_pos(t);
        if (p >= 0) begin
            held[p] = held[nheld-1];
            nheld--;
        end
    endtask

    task automatic cyc(bit pop, bit push, int ptag, bit mark, int mtag,
                       bit start, string rq);
        bit eok;
        int etag;
        @(negedge clk);
        alloc_req    = pop;
        free_req     = push;
        free_tag     = TAG_W'(ptag);
        mark_req     = mark;
        mark_tag     = TAG_W'(mtag);
        cancel_start = start;
        #1;
        if (mbusy) begin eok = 0; etag = 0; end
        else if (push) begin eok = 1; etag = ptag; end
        else if (sp > 0) begin eok = 1; etag = top_tag(); end
        else begin eok = 0; etag = 0; end
        check(alloc_ok == eok, {rq, " alloc_ok"}, alloc_ok, eok);
        check(alloc_tag == TAG_W'(etag), {rq, " alloc_tag"}, alloc_tag, etag);
        check(free_count == CNT_W'(sp), "R5 free_count", free_count, sp);
        check(cancel_busy == mbusy, "R8 cancel_busy", cancel_busy, mbusy);
        if (mbusy) begin
            check(cancel_valid == occ[midx], "R6 R8 cancel_valid", cancel_valid, occ[midx]);
            if (occ[midx])
                check(cancel_tag == TAG_W'(midx), "R8 cancel_tag", cancel_tag, midx);
        end else begin
            check(cancel_valid == 1'b0, "R8 idle cancel_valid", cancel_valid, 0);
        end
        // model update
        if (mbusy) begin
            if (occ[midx]) begin
                stk[sp] = midx; sp++; occ[midx] = 0; drop_held(midx);
            end
            midx++;
            if (midx == POOL_TAGS) begin mbusy = 0; midx = 0; end
        end else begin
            if (mark) occ[mtag] = 1;
            if (push) begin occ[ptag] = 0; drop_held(ptag); end
            if (push && pop) begin
                held[nheld] = ptag; nheld++;
            end else if (push) begin
                stk[sp] = ptag; sp++;
            end else if (pop && sp > 0) begin
                sp--; held[nheld] = stk[sp]; nheld++;
            end
            if (start) begin mbusy = 1; midx = 0; end
        end
    endtask

    task automatic idle_cycle(string rq);
        cyc(0, 0, 0, 0, 0, 0, rq);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int r, p, t;
        void'($urandom(32'd20240611));
        for (int i = 0; i < POOL_TAGS; i++) begin
            stk[i] = POOL_TAGS - 1 - i; occ[i] = 0;
        end
        sp = POOL_TAGS; nheld = 0; mbusy = 0; midx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check(free_count == CNT_W'(POOL_TAGS), "R1 reset free_count", free_count, POOL_TAGS);
        check(cancel_busy == 1'b0, "R1 reset cancel_busy", cancel_busy, 0);
        check(alloc_ok == 1'b1 && alloc_tag == '0, "R1 reset head", alloc_tag, 0);

        // R1 ascending grants after reset
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0, "R1");
        // R2 LIFO return order
        cyc(0, 1, 0, 0, 0, 0, "R2");
        cyc(0, 1, 2, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, 0, "R2");
        // R4 same-cycle return and grant
        cyc(1, 1, 1, 0, 0, 0, "R4");

        // R3 drain to empty, then request on empty
        while (sp > 0) cyc(1, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, 0, "R3");
        cyc(1, 0, 0, 0, 0, 0, "R3");
        idle_cycle("R3");
        cyc(1, 1, held[0], 0, 0, 0, "R4");
        cyc(0, 1, 77, 0, 0, 0, "R5");
        cyc(1, 0, 0, 0, 0, 0, "R2");

        // R6 R7 marks, one marked tag handed back before the walk
        cyc(0, 0, 0, 1, 5, 0, "R6");
        cyc(0, 0, 0, 1, 3, 0, "R6");
        cyc(0, 0, 0, 1, 9, 0, "R6");
        cyc(0, 1, 3, 0, 0, 0, "R7");
        cyc(0, 0, 0, 0, 0, 1, "R8");
        // R9 inputs during the walk have no effect
        cyc(1, 1, 20, 1, 21, 1, "R9");
        while (mbusy) cyc(1, 0, 0, 0, 0, 0, "R9");
        // R10 highest cancelled tag granted first
        cyc(1, 0, 0, 0, 0, 0, "R10");
        cyc(1, 0, 0, 0, 0, 0, "R10");
        cyc(1, 0, 0, 0, 0, 0, "R10");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            bit dp, du, dm, ds;
            int pt, mt;
            r  = $urandom % 100;
            dp = (r < 50);
            du = (nheld > 0) && (($urandom % 100) < 45);
            pt = du ? held[$urandom % nheld] : 0;
            dm = (nheld > 0) && (($urandom % 100) < 30);
            mt = dm ? held[$urandom % nheld] : 0;
            if (dm && du && mt == pt) dm = 0;
            ds = (($urandom % 1000) < 2);
            cyc(dp, du, pt, dm, mt, ds, "R2");
        end
        while (mbusy) idle_cycle("R8");
        p = 0; t = 0;
        idle_cycle("R5");
        summary();
    end
endmodule